// File: doc/BRIEF.md
# Boot Block Map and Protection Gate

This block sits between the command logic and the array controller of a 16-bit, 1M-word flash array. The array is split into 39 erase blocks of two sizes. There are eight small parameter blocks of 4K words and thirty-one main blocks of 32K words. The small blocks sit at one end of the address space, and a layout strap selects which end. From a 20-bit word address the block returns, combinationally, the block index, the block size class, and whether the block is one of the two write-protectable parameter blocks.

The same block also gates each program or erase request. A one-cycle start strobe makes it check two things: the write-protect input, for the two lockable blocks, and the program-voltage-valid flag. The voltage flag is captured only at that strobe. Exactly one cycle later the block answers with a one-cycle grant pulse or a one-cycle deny pulse. A refusal also sets a sticky lock-error flag, a voltage-error flag, or both, for the status register. These flags stay set until a clear input is applied.

Top module: `boot_map_guard`

## Requirements
- R1: With `top_boot_i` = 0, an address whose bits [19:15] are zero is a parameter block: `blk_idx_o` equals address bits [14:12] and `blk_main_o` = 0.
- R2: With `top_boot_i` = 0, an address whose bits [19:15] are nonzero is a main block: `blk_idx_o` = 7 + bits [19:15] (08000h is block 8, FFFFFh is block 38) and `blk_main_o` = 1.
- R3: With `top_boot_i` = 1, the map is mirrored and decoded as R1/R2 on the bitwise-inverted address. So FF000h–FFFFFh is block 0, F8000h–F8FFFh is block 7, F0000h–F7FFFh is block 8, and 00000h–07FFFh is block 38.
- R4: `blk_lockable_o` is 1 exactly for blocks 0 and 1 (both are parameter blocks), in either layout.
- R5: For each cycle with `op_start_i` high, exactly one of `grant_o` or `deny_o` is high for one cycle on the following cycle. Neither is high in any other cycle.
- R6: A request to a lockable block while `wp_i` = 0 is denied and sets `lock_err_o`. With `wp_i` = 1 the same request is granted when the voltage is valid. `wp_i` has no effect on blocks 2..38.
- R7: `vpp_ok_i` = 0 at the start strobe denies the request and sets `vpp_err_o`. The flag is captured into `vpp_cap_o` only at a start strobe. Later changes of `vpp_ok_i` neither alter `vpp_cap_o` nor produce a grant or deny.
- R8: `lock_err_o` and `vpp_err_o` stay set until `clr_err_i` is high at a clock edge. If a new refusal occurs at the same edge, setting wins over clearing.
- R9: After reset, `grant_o`, `deny_o`, `lock_err_o`, `vpp_err_o` and `vpp_cap_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 20 | Word address |
| top_boot_i | input | 1 | Layout strap: 1 = parameter blocks at top of address space |
| op_start_i | input | 1 | One-cycle program/erase start strobe |
| wp_i | input | 1 | Write-protect, 0 = lockable blocks protected |
| vpp_ok_i | input | 1 | Program voltage above enable threshold |
| clr_err_i | input | 1 | Clears the sticky error flags |
| blk_idx_o | output | 6 | Block index 0..38 |
| blk_main_o | output | 1 | Size class: 1 = 32K-word main block, 0 = 4K-word parameter block |
| blk_lockable_o | output | 1 | Block is one of the two protectable parameter blocks |
| grant_o | output | 1 | Request permitted (pulse) |
| deny_o | output | 1 | Request refused (pulse) |
| lock_err_o | output | 1 | Sticky: refused by write-protect |
| vpp_err_o | output | 1 | Sticky: refused by low program voltage |
| vpp_cap_o | output | 1 | Voltage flag captured at last start strobe |

## Verification
The decoder is tried with addresses at both edges of every kind of region: the first and last word of the boot parameter region, the last parameter block, the first main block, a mid-array main block, and the far end of the array. Each of these is given in both layouts, so an off-by-one at a region boundary shows up separately from a missing mirror. The gate is tried with each combination of protect level, voltage level and lockable or unlockable block. This separates a lock check that leaks onto block 2 from a voltage check that ignores the layout. A voltage drop right after a granted start, and a clear that coincides with a new refusal, show apart sampling-once from continuous checking and set-priority from clear-priority.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;
  localparam int ADDR_W      = 20;
  localparam int PARAM_SHIFT = 12;  // 4K-word parameter block
  localparam int MAIN_SHIFT  = 15;  // 32K-word main block
  localparam int N_LOCK      = 2;
  localparam int N_PARAM     = 1 << (MAIN_SHIFT - PARAM_SHIFT);
  localparam int N_MAIN      = (1 << (ADDR_W - MAIN_SHIFT)) - 1;
  localparam int N_BLK       = N_PARAM + N_MAIN;
  localparam int IDX_W       = $clog2(N_BLK);

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             main;
    logic             lockable;
  } blk_info_t;
endpackage

// File: rtl/bbm_decode.sv
module bbm_decode
  import boot_map_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              top_boot_i,
  output blk_info_t         info_o
);
  localparam int M_W = ADDR_W - MAIN_SHIFT;
  localparam int P_W = MAIN_SHIFT - PARAM_SHIFT;

  logic [ADDR_W-1:0] norm;
  logic [M_W-1:0]    main_sel;
  logic [P_W-1:0]    par_sel;

  // top layout is the bottom layout seen through an inverted address
  assign norm     = top_boot_i ? ~addr_i : addr_i;
  assign main_sel = norm[ADDR_W-1:MAIN_SHIFT];
  assign par_sel  = norm[MAIN_SHIFT-1:PARAM_SHIFT];

  always_comb begin
    info_o.main = (main_sel != '0);
    if (info_o.main) info_o.idx = IDX_W'(N_PARAM - 1) + IDX_W'(main_sel);
    else             info_o.idx = IDX_W'(par_sel);
    info_o.lockable = !info_o.main && (int'(par_sel) < N_LOCK);
  end

  always_comb begin
    if (!$isunknown(addr_i)) begin
      a_idx_range_r2: assert (int'(info_o.idx) < N_BLK);
      a_lock_small_r4: assert (!(info_o.lockable && info_o.main));
    end
  end
endmodule

// File: rtl/bbm_gate.sv
module bbm_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic lockable_i,
  input  logic wp_i,
  input  logic vpp_ok_i,
  input  logic clr_i,
  output logic grant_o,
  output logic deny_o,
  output logic lock_err_o,
  output logic vpp_err_o,
  output logic vpp_cap_o
);
  logic lock_fail, vpp_fail;

  assign lock_fail = start_i && lockable_i && !wp_i;
  assign vpp_fail  = start_i && !vpp_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o    <= 1'b0;
      deny_o     <= 1'b0;
      lock_err_o <= 1'b0;
      vpp_err_o  <= 1'b0;
      vpp_cap_o  <= 1'b0;
    end else begin
      grant_o    <= start_i && !lock_fail && !vpp_fail;
      deny_o     <= lock_fail || vpp_fail;
      // set wins over clear
      lock_err_o <= (lock_err_o && !clr_i) || lock_fail;
      vpp_err_o  <= (vpp_err_o && !clr_i) || vpp_fail;
      if (start_i) vpp_cap_o <= vpp_ok_i;
    end
  end

  p_outcome_needs_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o || deny_o) |-> $past(start_i));
  p_start_gives_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (grant_o ^ deny_o));
  p_lock_refuse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && lockable_i && !wp_i) |=> (deny_o && lock_err_o));
  p_vpp_refuse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !vpp_ok_i) |=> (deny_o && vpp_err_o));
  p_vpp_cap_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(vpp_cap_o));
  p_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_err_o && !clr_i) |=> lock_err_o);
  p_vpp_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_err_o && !clr_i) |=> vpp_err_o);
endmodule

// File: rtl/boot_map_guard.sv
module boot_map_guard
  import boot_map_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              top_boot_i,
  input  logic              op_start_i,
  input  logic              wp_i,
  input  logic              vpp_ok_i,
  input  logic              clr_err_i,
  output logic [IDX_W-1:0]  blk_idx_o,
  output logic              blk_main_o,
  output logic              blk_lockable_o,
  output logic              grant_o,
  output logic              deny_o,
  output logic              lock_err_o,
  output logic              vpp_err_o,
  output logic              vpp_cap_o
);
  blk_info_t info;

  bbm_decode u_decode (
    .addr_i     (addr_i),
    .top_boot_i (top_boot_i),
    .info_o     (info)
  );

  assign blk_idx_o      = info.idx;
  assign blk_main_o     = info.main;
  assign blk_lockable_o = info.lockable;

  bbm_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (op_start_i),
    .lockable_i (info.lockable),
    .wp_i       (wp_i),
    .vpp_ok_i   (vpp_ok_i),
    .clr_i      (clr_err_i),
    .grant_o    (grant_o),
    .deny_o     (deny_o),
    .lock_err_o (lock_err_o),
    .vpp_err_o  (vpp_err_o),
    .vpp_cap_o  (vpp_cap_o)
  );

  p_unlocked_main_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_start_i && blk_main_o && vpp_ok_i) |=> grant_o);
endmodule

// File: tb/boot_map_guard_tb.sv
module boot_map_guard_tb;
  localparam int CLK_P = 10;
  localparam int N_VEC = 13;
  // {top, addr[19:0], idx[5:0], main, lockable}
  localparam logic [28:0] VEC [N_VEC] = '{
    {1'b0, 20'h00000, 6'd0,  1'b0, 1'b1},
    {1'b0, 20'h01FFF, 6'd1,  1'b0, 1'b1},
    {1'b0, 20'h02000, 6'd2,  1'b0, 1'b0},
    {1'b0, 20'h07ABC, 6'd7,  1'b0, 1'b0},
    {1'b0, 20'h08000, 6'd8,  1'b1, 1'b0},
    {1'b0, 20'h80000, 6'd23, 1'b1, 1'b0},
    {1'b0, 20'hFFFFF, 6'd38, 1'b1, 1'b0},
    {1'b1, 20'hFF000, 6'd0,  1'b0, 1'b1},
    {1'b1, 20'hFEFFF, 6'd1,  1'b0, 1'b1},
    {1'b1, 20'hF8000, 6'd7,  1'b0, 1'b0},
    {1'b1, 20'hF7FFF, 6'd8,  1'b1, 1'b0},
    {1'b1, 20'h80000, 6'd22, 1'b1, 1'b0},
    {1'b1, 20'h00000, 6'd38, 1'b1, 1'b0}
  };

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [19:0] addr = '0;
  logic        top = 1'b0, start = 1'b0, wp = 1'b1, vpp = 1'b1, clr = 1'b0;
  logic [5:0]  idx;
  logic        mainb, lockb, grant, deny, lerr, verr, vcap;
  int checks = 0, bad = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  boot_map_guard u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .top_boot_i(top),
    .op_start_i(start), .wp_i(wp), .vpp_ok_i(vpp), .clr_err_i(clr),
    .blk_idx_o(idx), .blk_main_o(mainb), .blk_lockable_o(lockb),
    .grant_o(grant), .deny_o(deny), .lock_err_o(lerr), .vpp_err_o(verr),
    .vpp_cap_o(vcap)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // start strobe over one edge; sample at following negedge
  task automatic request(input logic t, input logic [19:0] a, input logic w, input logic v);
    @(negedge clk);
    top = t; addr = a; wp = w; vpp = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=<5000", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 grant", grant, 0); chk("R9 deny", deny, 0);
    chk("R9 lock_err", lerr, 0); chk("R9 vpp_err", verr, 0);
    chk("R9 vpp_cap", vcap, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      top = VEC[i][28]; addr = VEC[i][27:8];
      #1;
      chk(top ? "R3 idx" : (VEC[i][2] ? "R2 idx" : "R1 idx"), idx, VEC[i][7:2]);
      chk(top ? "R3 size" : "R1 R2 size", mainb, VEC[i][1]);
      chk("R4 lockable", lockb, VEC[i][0]);
    end

    // R6: lockable block, protect released, voltage good -> grant
    request(1'b0, 20'h01000, 1'b1, 1'b1);
    chk("R5 R6 grant", grant, 1); chk("R6 deny", deny, 0); chk("R7 cap", vcap, 1);
    @(negedge clk);
    chk("R5 pulse grant", grant, 0);

    // R6: block 2 ignores wp
    request(1'b0, 20'h02000, 1'b0, 1'b1);
    chk("R6 unlocked grant", grant, 1); chk("R6 no lock_err", lerr, 0);

    // R6: top layout, block 0 protected
    request(1'b1, 20'hFF800, 1'b0, 1'b1);
    chk("R6 deny", deny, 1); chk("R5 no grant", grant, 0); chk("R6 lock_err", lerr, 1);
    @(negedge clk);
    chk("R5 pulse deny", deny, 0); chk("R8 sticky lock", lerr, 1);
    repeat (3) @(negedge clk);
    chk("R8 still lock", lerr, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R8 cleared", lerr, 0);

    // R7: low voltage on main block
    request(1'b0, 20'h40000, 1'b1, 1'b0);
    chk("R7 deny", deny, 1); chk("R7 vpp_err", verr, 1);
    chk("R7 cap low", vcap, 0); chk("R7 no lock_err", lerr, 0);

    // R7: granted, then voltage changes mid-operation
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R8 vpp cleared", verr, 0);
    request(1'b0, 20'h40000, 1'b1, 1'b1);
    chk("R7 grant", grant, 1);
    vpp = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 cap held", vcap, 1); chk("R7 no late err", verr, 0);
    chk("R7 no late deny", deny, 0);

    // R8: clear coinciding with new refusal -> set wins; both causes at once
    @(negedge clk);
    top = 1'b0; addr = 20'h00000; wp = 1'b0; vpp = 1'b0; start = 1'b1; clr = 1'b1;
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
    chk("R8 set wins lock", lerr, 1); chk("R8 set wins vpp", verr, 1);
    chk("R6 R7 deny", deny, 1);

    // R5: idle cycles give nothing
    vpp = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 idle grant", grant, 0); chk("R5 idle deny", deny, 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule